// File: doc/BRIEF.md
# Automatic Thermal Sensor Polling Controller

This block runs a temperature-sensing converter without software involvement. Once software turns on automatic mode, the controller works through the channels it has been told to watch, lowest index first, and converts one channel at a time. It uses a request/done handshake toward the converter. After each round it waits a programmable number of clock ticks before starting the next one. That wait is a long normal interval while every watched channel reads cool, and a shorter interval while any of them reads warm. Converter codes fall as the die heats, so a reading counts as over a threshold when its code is below that threshold.

Each channel has two thresholds: an alarm level and a shutdown level. Each level has a shared debounce count that sets how many consecutive over-threshold samples it needs before it acts. An alarm sets a pending bit, and that bit drives the interrupt line when it is enabled. A shutdown latches per channel. It can drive a pin whose polarity is programmable, and it can drive an active-high request to the reset controller. The choice is made per channel. The latch holds until automatic mode is switched off.

Top module: `thermal_poll_ctrl`

## Requirements
- R1: After reset, adc_req, irq and shut_rst are 0, shut_gpio is 1 (the polarity bit resets to 0, which means active-low), and every data register (0x20 + 4n) reads 0.
- R2: With control bit 0 set, requests are issued only for channels whose enable bit (control bit 4+n) is 1, in ascending channel order. adc_req and adc_chan hold steady until adc_done is seen.
- R3: The first request of a round comes P+1 cycles after the cycle in which the previous round's last adc_done was high. P is the normal period (0x68) while no enabled channel's latest sample was over a threshold, and the high-temperature period (0x6C) otherwise.
- R4: The data register of channel n (0x20 + 4n) holds that channel's latest conversion result, readable from the cycle after adc_done.
- R5: Pending bit n (0x0C bit n) is set on the sample that completes the alarm debounce count (0x60) of consecutive samples with code below the alarm threshold (0x30 + 4n). A sample at or above the threshold restarts the count, and every further over-threshold sample sets the bit again.
- R6: irq is the OR of pending bits n that have alarm enable bit n of 0x08 set. A masked pending bit still reads back as 1.
- R7: A write to 0x0C clears the pending bits written as 0 and keeps those written as 1.
- R8: After the shutdown debounce count (0x64) of consecutive samples below the shutdown threshold (0x40 + 4n), the shutdown of channel n latches. It drives shut_rst when 0x08 bit 8+n is set and activates shut_gpio when 0x08 bit 4+n is set. Later cool samples do not release it.
- R9: Control bit 8 sets the shut_gpio polarity: with 1 the pin is high when active, with 0 it is low when active and high when idle.
- R10: Clearing control bit 0 drops adc_req one cycle after the write takes effect and issues no further requests. It also releases the shutdown latches and restarts the debounce counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| adc_req | output | 1 | Conversion request, held until done |
| adc_chan | output | CHW | Channel to convert |
| adc_done | input | 1 | Conversion finished, result valid |
| adc_code | input | DW | Conversion result |
| irq | output | 1 | Alarm interrupt |
| shut_gpio | output | 1 | Shutdown pin, programmable polarity |
| shut_rst | output | 1 | Active-high shutdown request to the reset controller |

## Verification
Every sample result lands on the clock edge that captures adc_done. The data register, pending bits, irq and both shutdown outputs are therefore due one cycle after the cycle in which the converter model raised done. The scoreboard monitor compares them at the falling edge that follows that capture edge. Period timing is measured with the bench's own edge counter, from the cycle in which the last done of a round was driven to the falling edge at which the next request is first seen. The expected value is period plus one. Register writes take effect at the next rising edge, so register and pin effects of a write are checked at the falling edge after that edge.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_GAP  = 2'd1,
        ST_CONV = 2'd2
    } sched_st_e;

    localparam int ADDR_CTRL      = 'h04;
    localparam int ADDR_IEN       = 'h08;
    localparam int ADDR_PEND      = 'h0C;
    localparam int ADDR_DATA_BASE = 'h20;
    localparam int ADDR_ATHR_BASE = 'h30;
    localparam int ADDR_STHR_BASE = 'h40;
    localparam int ADDR_ADEB      = 'h60;
    localparam int ADDR_SDEB      = 'h64;
    localparam int ADDR_PNORM     = 'h68;
    localparam int ADDR_PHOT      = 'h6C;

    localparam int FLD_CHEN = 4;
    localparam int FLD_GIEN = 4;
    localparam int FLD_RIEN = 8;
    localparam int BIT_POL  = 8;

endpackage

// File: rtl/tpc_sched.sv
module tpc_sched
    import tpc_pkg::*;
#(
    parameter int NCH = 3,
    parameter int PW  = 16,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic [NCH-1:0] chan_en,
    input  logic           hot,
    input  logic [PW-1:0]  per_norm,
    input  logic [PW-1:0]  per_hot,
    input  logic           adc_done,
    output logic           adc_req,
    output logic [CHW-1:0] adc_chan,
    output logic           smp_valid
);

    typedef struct packed {
        sched_st_e      st;
        logic [PW-1:0]  cnt;
        logic [CHW-1:0] chan;
    } sched_t;

    sched_t s_d, s_q;
    logic           first_hit, above_hit;
    logic [CHW-1:0] first_idx, above_idx;
    logic [PW-1:0]  gap_len;

    always_comb begin
        first_hit = 1'b0;
        first_idx = '0;
        above_hit = 1'b0;
        above_idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (chan_en[i]) begin
                first_hit = 1'b1;
                first_idx = CHW'(i);
                if (i > int'(s_q.chan)) begin
                    above_hit = 1'b1;
                    above_idx = CHW'(i);
                end
            end
        end
    end

    always_comb begin
        s_d     = s_q;
        gap_len = hot ? per_hot : per_norm;
        if (gap_len == '0) gap_len = PW'(1);
        case (s_q.st)
            ST_IDLE: begin
                s_d.st  = ST_GAP;
                s_d.cnt = '0;
            end
            ST_GAP: begin
                if (s_q.cnt >= gap_len - PW'(1)) begin
                    s_d.cnt = '0;
                    if (first_hit) begin
                        s_d.st   = ST_CONV;
                        s_d.chan = first_idx;
                    end
                end else begin
                    s_d.cnt = s_q.cnt + PW'(1);
                end
            end
            ST_CONV: begin
                if (adc_done) begin
                    if (above_hit) begin
                        s_d.chan = above_idx;
                    end else begin
                        s_d.st  = ST_GAP;
                        s_d.cnt = '0;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
        if (!run) begin
            s_d.st  = ST_IDLE;
            s_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, cnt: '0, chan: '0};
        else        s_q <= s_d;
    end

    assign adc_req   = (s_q.st == ST_CONV);
    assign adc_chan  = s_q.chan;
    assign smp_valid = adc_req && adc_done;

    // R10
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !adc_req);

    // R2
    chan_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_req && !adc_done) |=> $stable(adc_chan));

endmodule

// File: rtl/tpc_chan.sv
module tpc_chan #(
    parameter int DW  = 12,
    parameter int DBW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           smp_valid,
    input  logic [DW-1:0]  smp_code,
    input  logic [DW-1:0]  thr_alarm,
    input  logic [DW-1:0]  thr_shut,
    input  logic [DBW-1:0] deb_alarm,
    input  logic [DBW-1:0] deb_shut,
    output logic [DW-1:0]  data_o,
    output logic           hot_o,
    output logic           alarm_evt,
    output logic           shut_o
);

    typedef struct packed {
        logic [DW-1:0]  data;
        logic [DBW-1:0] acnt;
        logic [DBW-1:0] scnt;
        logic           hot;
        logic           shut;
    } chan_t;

    chan_t c_d, c_q;
    logic [DBW-1:0] adeb, sdeb;
    logic           a_over, s_over;

    always_comb begin
        c_d       = c_q;
        alarm_evt = 1'b0;
        adeb      = (deb_alarm == '0) ? DBW'(1) : deb_alarm;
        sdeb      = (deb_shut  == '0) ? DBW'(1) : deb_shut;
        a_over    = smp_code < thr_alarm;
        s_over    = smp_code < thr_shut;
        if (smp_valid) begin
            c_d.data = smp_code;
            c_d.hot  = a_over || s_over;
            if (a_over) begin
                c_d.acnt  = (c_q.acnt >= adeb) ? c_q.acnt : c_q.acnt + DBW'(1);
                alarm_evt = (c_d.acnt >= adeb);
            end else begin
                c_d.acnt = '0;
            end
            if (s_over) begin
                c_d.scnt = (c_q.scnt >= sdeb) ? c_q.scnt : c_q.scnt + DBW'(1);
                if (c_d.scnt >= sdeb) c_d.shut = 1'b1;
            end else begin
                c_d.scnt = '0;
            end
        end
        if (!run) begin
            c_d.acnt  = '0;
            c_d.scnt  = '0;
            c_d.hot   = 1'b0;
            c_d.shut  = 1'b0;
            alarm_evt = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign data_o = c_q.data;
    assign hot_o  = c_q.hot;
    assign shut_o = c_q.shut;

    // R8
    shut_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shut_o && run) |=> shut_o);

    // R4
    data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(data_o));

endmodule

// File: rtl/thermal_poll_ctrl.sv
module thermal_poll_ctrl
    import tpc_pkg::*;
#(
    parameter int NCH = 3,
    parameter int DW  = 12,
    parameter int DBW = 8,
    parameter int PW  = 16,
    parameter int AW  = 8,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_wen,
    input  logic [AW-1:0]  reg_addr,
    input  logic [31:0]    reg_wdata,
    output logic [31:0]    reg_rdata,
    output logic           adc_req,
    output logic [CHW-1:0] adc_chan,
    input  logic           adc_done,
    input  logic [DW-1:0]  adc_code,
    output logic           irq,
    output logic           shut_gpio,
    output logic           shut_rst
);

    typedef struct packed {
        logic                     en;
        logic                     pol;
        logic [NCH-1:0]           chen;
        logic [NCH-1:0]           aien;
        logic [NCH-1:0]           gien;
        logic [NCH-1:0]           rien;
        logic [NCH-1:0]           pend;
        logic [NCH-1:0][DW-1:0]   athr;
        logic [NCH-1:0][DW-1:0]   sthr;
        logic [DBW-1:0]           adeb;
        logic [DBW-1:0]           sdeb;
        logic [PW-1:0]            pnorm;
        logic [PW-1:0]            phot;
    } regs_t;

    regs_t r_d, r_q;

    logic                   smp_valid;
    logic [NCH-1:0][DW-1:0] ch_data;
    logic [NCH-1:0]         ch_hot, ch_alarm, ch_shut;
    logic                   gpio_act;

    always_comb begin
        r_d = r_q;
        if (reg_wen) begin
            if (reg_addr == AW'(ADDR_CTRL)) begin
                r_d.en   = reg_wdata[0];
                r_d.pol  = reg_wdata[BIT_POL];
                r_d.chen = reg_wdata[FLD_CHEN +: NCH];
            end
            if (reg_addr == AW'(ADDR_IEN)) begin
                r_d.aien = reg_wdata[0 +: NCH];
                r_d.gien = reg_wdata[FLD_GIEN +: NCH];
                r_d.rien = reg_wdata[FLD_RIEN +: NCH];
            end
            if (reg_addr == AW'(ADDR_PEND))  r_d.pend  = r_q.pend & reg_wdata[NCH-1:0];
            if (reg_addr == AW'(ADDR_ADEB))  r_d.adeb  = reg_wdata[DBW-1:0];
            if (reg_addr == AW'(ADDR_SDEB))  r_d.sdeb  = reg_wdata[DBW-1:0];
            if (reg_addr == AW'(ADDR_PNORM)) r_d.pnorm = reg_wdata[PW-1:0];
            if (reg_addr == AW'(ADDR_PHOT))  r_d.phot  = reg_wdata[PW-1:0];
            for (int i = 0; i < NCH; i++) begin
                if (reg_addr == AW'(ADDR_ATHR_BASE + 4 * i)) r_d.athr[i] = reg_wdata[DW-1:0];
                if (reg_addr == AW'(ADDR_STHR_BASE + 4 * i)) r_d.sthr[i] = reg_wdata[DW-1:0];
            end
        end
        r_d.pend = r_d.pend | ch_alarm;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.adeb  <= DBW'(10);
            r_q.sdeb  <= DBW'(10);
            r_q.pnorm <= PW'(1000);
            r_q.phot  <= PW'(100);
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == AW'(ADDR_CTRL)) begin
            reg_rdata[0]               = r_q.en;
            reg_rdata[BIT_POL]         = r_q.pol;
            reg_rdata[FLD_CHEN +: NCH] = r_q.chen;
        end
        if (reg_addr == AW'(ADDR_IEN)) begin
            reg_rdata[0 +: NCH]        = r_q.aien;
            reg_rdata[FLD_GIEN +: NCH] = r_q.gien;
            reg_rdata[FLD_RIEN +: NCH] = r_q.rien;
        end
        if (reg_addr == AW'(ADDR_PEND))  reg_rdata[NCH-1:0] = r_q.pend;
        if (reg_addr == AW'(ADDR_ADEB))  reg_rdata = 32'(r_q.adeb);
        if (reg_addr == AW'(ADDR_SDEB))  reg_rdata = 32'(r_q.sdeb);
        if (reg_addr == AW'(ADDR_PNORM)) reg_rdata = 32'(r_q.pnorm);
        if (reg_addr == AW'(ADDR_PHOT))  reg_rdata = 32'(r_q.phot);
        for (int i = 0; i < NCH; i++) begin
            if (reg_addr == AW'(ADDR_DATA_BASE + 4 * i)) reg_rdata = 32'(ch_data[i]);
            if (reg_addr == AW'(ADDR_ATHR_BASE + 4 * i)) reg_rdata = 32'(r_q.athr[i]);
            if (reg_addr == AW'(ADDR_STHR_BASE + 4 * i)) reg_rdata = 32'(r_q.sthr[i]);
        end
    end

    tpc_sched #(.NCH(NCH), .PW(PW)) i_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (r_q.en),
        .chan_en   (r_q.chen),
        .hot       (|(ch_hot & r_q.chen)),
        .per_norm  (r_q.pnorm),
        .per_hot   (r_q.phot),
        .adc_done  (adc_done),
        .adc_req   (adc_req),
        .adc_chan  (adc_chan),
        .smp_valid (smp_valid)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        tpc_chan #(.DW(DW), .DBW(DBW)) i_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (r_q.en),
            .smp_valid (smp_valid && (adc_chan == CHW'(g))),
            .smp_code  (adc_code),
            .thr_alarm (r_q.athr[g]),
            .thr_shut  (r_q.sthr[g]),
            .deb_alarm (r_q.adeb),
            .deb_shut  (r_q.sdeb),
            .data_o    (ch_data[g]),
            .hot_o     (ch_hot[g]),
            .alarm_evt (ch_alarm[g]),
            .shut_o    (ch_shut[g])
        );
    end

    assign irq       = |(r_q.pend & r_q.aien);
    assign gpio_act  = |(ch_shut & r_q.gien);
    assign shut_gpio = r_q.pol ? gpio_act : ~gpio_act;
    assign shut_rst  = |(ch_shut & r_q.rien);

    // R10
    off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.en |=> !(|ch_shut));

    // R5
    pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(r_q.pend & ~$past(r_q.pend))) |-> (|$past(ch_alarm)));

endmodule

// File: tb/test_thermal_poll_ctrl.sv
module test_thermal_poll_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        adc_req, adc_done;
    logic [1:0]  adc_chan;
    logic [11:0] adc_code;
    logic        irq, shut_gpio, shut_rst;

    always #10 clk = ~clk;

    thermal_poll_ctrl i_thermal_poll_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .adc_req(adc_req),
        .adc_chan(adc_chan), .adc_done(adc_done), .adc_code(adc_code),
        .irq(irq), .shut_gpio(shut_gpio), .shut_rst(shut_rst)
    );

    int n_chk = 0, n_fail = 0, cyc = 0, last_done = 0;
    logic done_e = 1'b0;
    logic [2:0] exp_q[$];

    int athr[3], sthr[3], acnt[3], scnt[3];
    int adeb = 3, sdeb = 2;
    logic [2:0] pend = '0, sh = '0, aien = '0, gien = '0, rien = '0;
    logic pol = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;
    always @(posedge clk) done_e <= adc_done;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // scoreboard monitor: results are due one cycle after done
    always @(negedge clk) begin
        if (done_e) begin
            logic [2:0] e;
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R5 scoreboard empty actual=1 expected=0");
            end else begin
                e = exp_q.pop_front();
                chk("R5/R6 irq after sample", irq, e[2]);
                chk("R8/R9 shut_gpio after sample", shut_gpio, e[1]);
                chk("R8 shut_rst after sample", shut_rst, e[0]);
            end
        end
    end

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = 8'(a); reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 8'(a);
        #1 d = reg_rdata;
    endtask

    task automatic expect_pins();
        logic g;
        g = |(sh & gien);
        exp_q.push_back({|(pend & aien), pol ? g : ~g, |(sh & rien)});
    endtask

    // converter model and expected-value driver
    task automatic convert(int ch, int code, int gap_exp);
        while (!adc_req) @(negedge clk);
        chk("R2 channel order", int'(adc_chan), ch);
        if (gap_exp > 0) chk("R3 round gap", cyc - last_done, gap_exp);
        repeat (2) @(negedge clk);
        chk("R2 request held", int'(adc_req), 1);
        if (code < athr[ch]) begin
            if (acnt[ch] < adeb) acnt[ch]++;
            if (acnt[ch] >= adeb) pend[ch] = 1'b1;
        end else acnt[ch] = 0;
        if (code < sthr[ch]) begin
            if (scnt[ch] < sdeb) scnt[ch]++;
            if (scnt[ch] >= sdeb) sh[ch] = 1'b1;
        end else scnt[ch] = 0;
        expect_pins();
        adc_done = 1'b1; adc_code = 12'(code);
        last_done = cyc;
        @(negedge clk);
        adc_done = 1'b0;
    endtask

    task automatic pair(int c1, int c2, int gap1);
        convert(1, c1, gap1);
        convert(2, c2, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R2 watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        reg_wen = 1'b0; reg_addr = '0; reg_wdata = '0;
        adc_done = 1'b0; adc_code = '0;
        for (int i = 0; i < 3; i++) begin
            athr[i] = 3600; sthr[i] = 3450; acnt[i] = 0; scnt[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 adc_req", adc_req, 0);
        chk("R1 irq", irq, 0);
        chk("R1 shut_rst", shut_rst, 0);
        chk("R1 shut_gpio idle", shut_gpio, 1);
        for (int i = 0; i < 3; i++) begin
            rd('h20 + 4 * i, v);
            chk("R1 data reads zero", int'(v), 0);
        end

        for (int i = 0; i < 3; i++) begin
            wr('h30 + 4 * i, 32'(athr[i]));
            wr('h40 + 4 * i, 32'(sthr[i]));
        end
        wr('h60, 32'(adeb));
        wr('h64, 32'(sdeb));
        wr('h68, 32'd20);
        wr('h6C, 32'd5);
        wr('h08, 32'h426);
        aien = 3'b110; gien = 3'b010; rien = 3'b100;
        wr('h04, 32'h61);

        // cool rounds, channel 0 skipped
        pair(3700, 3710, 0);
        pair(3700, 3705, 21);       // R3 normal period 20
        rd('h24, v); chk("R4 data ch1", int'(v), 3700);
        rd('h28, v); chk("R4 data ch2", int'(v), 3705);

        // alarm debounce with restart (R5)
        pair(3550, 3700, 0);
        pair(3550, 3700, 6);        // R3 hot period 5
        pair(3700, 3700, 0);
        pair(3550, 3700, 21);       // R3 back to normal
        pair(3550, 3700, 0);
        pair(3550, 3700, 0);
        rd('h0C, v); chk("R5 pending ch1", int'(v), 2);
        chk("R6 irq raised", irq, 1);

        // R6 masking
        wr('h08, 32'h424); aien = 3'b100;
        chk("R6 irq masked", irq, 0);
        rd('h0C, v); chk("R6 masked pending readable", int'(v), 2);
        wr('h08, 32'h426); aien = 3'b110;
        chk("R6 irq unmasked", irq, 1);

        // R7 write-zero-to-clear
        wr('h0C, ~32'h2); pend = pend & 3'b101;
        chk("R7 irq after clear", irq, 0);
        rd('h0C, v); chk("R7 pending cleared", int'(v), 0);

        // R8 shutdown to reset request, latched
        pair(3700, 3400, 0);
        pair(3700, 3400, 0);
        pair(3700, 3400, 0);
        rd('h0C, v); chk("R5 pending ch2", int'(v), 4);
        wr('h0C, 32'hFFFF_FFFF);
        rd('h0C, v); chk("R7 ones keep pending", int'(v), 4);
        pair(3700, 3700, 0);
        chk("R8 shut_rst latched", shut_rst, 1);

        // R8 shutdown to pin, then R9 polarity
        pair(3400, 3700, 0);
        pair(3400, 3700, 0);
        chk("R9 active-low pin", shut_gpio, 0);
        wr('h04, 32'h161); pol = 1'b1;
        chk("R9 active-high pin", shut_gpio, 1);

        // R10 disable
        wr('h04, 32'h160);
        for (int i = 0; i < 3; i++) begin acnt[i] = 0; scnt[i] = 0; end
        sh = '0;
        @(negedge clk);
        begin
            int seen = 0;
            for (int i = 0; i < 40; i++) begin
                if (adc_req) seen++;
                @(negedge clk);
            end
            chk("R10 no requests when off", seen, 0);
        end
        chk("R10 shut_rst released", shut_rst, 0);
        chk("R10 shut_gpio released", shut_gpio, 0);

        // R10 counts restart after re-enable
        wr('h04, 32'h161);
        pair(3700, 3400, 0);
        chk("R10 debounce restarted", shut_rst, 0);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule